// File: doc/BRIEF.md
# Receive Line Fault and Lock-Source Monitor

This block watches one serial receive channel and tells the clock recovery loop which clock to follow. It counts rising edges of the recovered character-rate clock over a fixed window of reference-clock cycles. The reference clock runs at the character rate, which is the bit rate divided by 16. When the count lies outside a configured band around nominal, the loop is steered back to the local reference. Only after the rate has stayed inside the band for several windows in a row is the loop allowed to follow the incoming data again.

A separate line-fault output combines that frequency verdict with two level inputs: a signal-detect indication from the line receiver and a lock indication for the reference. The fault output drops at once, without waiting for any clock, when either level input falls. Every other change of the output is registered on the reference clock. The recovered-clock count crosses into the reference domain as a Gray code through a synchronizer.

The block has no data stream. All pins are plain control and status levels, so there is no valid/ready handshake and no back-pressure.

Top module: `line_fault_monitor`

## Requirements
- R1: While `ref_rst_n` is low, `fault_n` is 0 and `track_data` is 0.
- R2: A measurement window is 2^WIN_LOG2 reference cycles. Reference edges are counted from 1 at the first rising edge with reset released. The first window (edges 1 to 2^WIN_LOG2) gives no verdict. Window j (j ≥ 2) ends at edge j·2^WIN_LOG2. Its verdict is in range when the number of recovered rising edges in it lies between LO_LIM and HI_LIM inclusive. The verdict acts on the outputs at edge j·2^WIN_LOG2+1.
- R3: When `sig_det` or `ref_lock` falls, `fault_n` goes to 0 at the same instant, with no reference edge needed. It stays 0 while either input is low.
- R4: `fault_n` rises only at a reference edge where an in-range verdict acts. The window must also be clean: both status inputs were high, and synchronized, at its opening edge, and never fell during it.
- R5: An out-of-range verdict drives both `fault_n` and `track_data` to 0.
- R6: `track_data` goes to 1 only when the verdict acting is the GOOD_WINDOWS-th in-range verdict in a row (default 2). Any out-of-range verdict restarts the run.
- R7: `track_data` does not depend on `sig_det` or `ref_lock`. A status drop leaves it unchanged.
- R8: A status pulse shorter than one reference cycle still drops `fault_n`. The output stays 0 until the verdict of a later clean, in-range window.
- R9: If a status input is still low at a window's opening edge, that window is not clean. A drop that spans a window boundary therefore keeps `fault_n` at 0 through the verdicts of both windows around the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local character-rate reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| rec_clk | input | 1 | Recovered character-rate clock from the recovery loop |
| rec_rst_n | input | 1 | Active-low asynchronous reset, recovered domain |
| sig_det | input | 1 | Line signal present (high = present) |
| ref_lock | input | 1 | Reference lock status (high = locked) |
| fault_n | output | 1 | Line fault indicator, 0 = fault |
| track_data | output | 1 | 1 = recovery loop may follow data, 0 = follow reference |

## Verification
A window counter that slips by one cycle moves every verdict by one edge. The bench compares both outputs with a behavioural model after every reference edge, so such a slip shows up at the first verdict, about two windows after reset. A stale or mis-converted count snapshot produces a wrong in-range decision, and it appears on `fault_n` and `track_data` one cycle after the affected window closes. A wrong clean flag or a broken hysteresis counter changes `fault_n` or `track_data` at a verdict edge where the model expects the old value. The asynchronous drop is sampled half a nanosecond after each injected fall, inside the reference cycle.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Result of one closed measurement window, handed to the arbiter.
  typedef struct packed {
    logic valid;     // one-cycle strobe, one per window after the first
    logic in_range;  // recovered edge count within limits
    logic clean;     // status inputs stayed good for the whole window
  } verdict_t;

endpackage

// File: rtl/rec_gray_counter.sv
module rec_gray_counter #(
  parameter int unsigned W = 18
) (
  input  logic         rec_clk,
  input  logic         rec_rst_n,
  output logic [W-1:0] gray_o
);

  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  // The Gray word is registered so that only one bit toggles per edge.
  always_ff @(posedge rec_clk or negedge rec_rst_n) begin
    if (!rec_rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end

endmodule

// File: rtl/gray_to_ref.sv
module gray_to_ref #(
  parameter int unsigned W      = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  logic [W-1:0] sync_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  // Bit i of the binary value is the XOR of all Gray bits at or above i.
  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(sync_q[STAGES-1] >> i);
  end

endmodule

// File: rtl/window_meter.sv
module window_meter
  import lfm_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned CNT_W    = 18,
  parameter int unsigned LO_LIM   = 65529,
  parameter int unsigned HI_LIM   = 65543
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_arst_n,
  input  logic [CNT_W-1:0] cnt_i,
  output verdict_t         verdict_o
);

  logic [WIN_LOG2-1:0] wcnt_q;
  logic                win_end;
  logic [CNT_W-1:0]    snap_q;
  logic [CNT_W-1:0]    delta;
  logic                primed_q;
  logic [1:0]          stat_sync_q;
  logic                clean_q;
  logic                in_range;

  assign win_end  = &wcnt_q;
  assign delta    = cnt_i - snap_q;
  assign in_range = (delta >= CNT_W'(LO_LIM)) && (delta <= CNT_W'(HI_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q    <= '0;
      snap_q    <= '0;
      primed_q  <= 1'b0;
      verdict_o <= '0;
    end else begin
      wcnt_q          <= wcnt_q + 1'b1;
      verdict_o.valid <= win_end && primed_q;
      if (win_end) begin
        snap_q             <= cnt_i;
        primed_q           <= 1'b1;
        verdict_o.in_range <= in_range;
        verdict_o.clean    <= clean_q;
      end
    end
  end

  // The status synchronizer and the clean flag are cleared at once by a status drop.
  always_ff @(posedge clk or negedge stat_arst_n) begin
    if (!stat_arst_n) begin
      stat_sync_q <= 2'b00;
      clean_q     <= 1'b0;
    end else begin
      stat_sync_q <= {stat_sync_q[0], 1'b1};
      if (win_end) clean_q <= stat_sync_q[1];
    end
  end

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o.valid |=> !verdict_o.valid);

  p_strobe_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_o.valid) |-> $past(win_end));

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lfm_pkg::*;
#(
  parameter int unsigned GOOD_WINDOWS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stat_arst_n,
  input  verdict_t verdict_i,
  output logic     fault_n_o,
  output logic     track_o
);

  localparam int unsigned GW = $clog2(GOOD_WINDOWS + 1);

  logic [GW-1:0] good_q;
  logic [GW-1:0] good_nx;

  always_comb begin
    good_nx = good_q;
    if (verdict_i.valid) begin
      if (!verdict_i.in_range)                  good_nx = '0;
      else if (good_q != GW'(GOOD_WINDOWS))     good_nx = good_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q  <= '0;
      track_o <= 1'b0;
    end else begin
      good_q  <= good_nx;
      track_o <= (good_nx == GW'(GOOD_WINDOWS));
    end
  end

  // A status drop acts as an asynchronous clear; the release waits for a verdict.
  always_ff @(posedge clk or negedge stat_arst_n) begin
    if (!stat_arst_n)          fault_n_o <= 1'b0;
    else if (verdict_i.valid)  fault_n_o <= verdict_i.in_range && verdict_i.clean;
  end

  p_fault_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_arst_n |-> !fault_n_o);

  p_release_needs_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n_o) |-> $past(verdict_i.valid && verdict_i.in_range && verdict_i.clean));

  p_bad_window_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_i.valid && !verdict_i.in_range) |=> (!track_o && !fault_n_o));

  p_track_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_o) |-> $past(verdict_i.valid && verdict_i.in_range));

  p_track_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_i.valid |=> $stable(track_o));

endmodule

// File: rtl/line_fault_monitor.sv
module line_fault_monitor
  import lfm_pkg::*;
#(
  parameter int unsigned WIN_LOG2     = 16,
  parameter int unsigned LO_LIM       = 65529,
  parameter int unsigned HI_LIM       = 65543,
  parameter int unsigned GOOD_WINDOWS = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic rec_clk,
  input  logic rec_rst_n,
  input  logic sig_det,
  input  logic ref_lock,
  output logic fault_n,
  output logic track_data
);

  // Two spare bits so a recovered clock up to four times nominal does not alias.
  localparam int unsigned CNT_W = WIN_LOG2 + 2;

  logic [CNT_W-1:0] rec_gray;
  logic [CNT_W-1:0] rec_bin;
  logic             stat_arst_n;
  verdict_t         verdict;

  assign stat_arst_n = ref_rst_n & sig_det & ref_lock;

  rec_gray_counter #(.W(CNT_W)) u_rec_cnt (
    .rec_clk   (rec_clk),
    .rec_rst_n (rec_rst_n),
    .gray_o    (rec_gray)
  );

  gray_to_ref #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (ref_clk),
    .rst_n  (ref_rst_n),
    .gray_i (rec_gray),
    .bin_o  (rec_bin)
  );

  window_meter #(
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W),
    .LO_LIM   (LO_LIM),
    .HI_LIM   (HI_LIM)
  ) u_meter (
    .clk         (ref_clk),
    .rst_n       (ref_rst_n),
    .stat_arst_n (stat_arst_n),
    .cnt_i       (rec_bin),
    .verdict_o   (verdict)
  );

  lock_arbiter #(.GOOD_WINDOWS(GOOD_WINDOWS)) u_arb (
    .clk         (ref_clk),
    .rst_n       (ref_rst_n),
    .stat_arst_n (stat_arst_n),
    .verdict_i   (verdict),
    .fault_n_o   (fault_n),
    .track_o     (track_data)
  );

endmodule

// File: tb/test_line_fault_monitor.sv
`timescale 1ns/1ps
module test_line_fault_monitor;

  localparam int WL  = 8;
  localparam int WIN = 1 << WL;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic ref_rst_n = 1'b0;
  logic rec_rst_n = 1'b0;
  logic sig_det = 1'b1;
  logic ref_lock = 1'b1;
  logic fault_n;
  logic track_data;

  real  rec_half = 4.0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // behavioural model state
  int    n = 0;
  bit    fault_e = 1'b0;
  bit    track_e = 1'b0;
  int    good_run = 0;
  bit    dirty = 1'b0;
  bit    armed = 1'b0;
  bit    pend_ok = 1'b0;
  bit    pend_clean = 1'b0;
  string tag = "R1";

  line_fault_monitor #(
    .WIN_LOG2 (WL),
    .LO_LIM   (250),
    .HI_LIM   (262)
  ) i_line_fault_monitor (
    .ref_clk    (ref_clk),
    .ref_rst_n  (ref_rst_n),
    .rec_clk    (rec_clk),
    .rec_rst_n  (rec_rst_n),
    .sig_det    (sig_det),
    .ref_lock   (ref_lock),
    .fault_n    (fault_n),
    .track_data (track_data)
  );

  always #4 ref_clk = ~ref_clk;

  initial begin
    #3;
    forever begin
      #(rec_half) rec_clk = ~rec_clk;
    end
  end

  task automatic chk(string rq, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Model: windows of WIN edges; rate in range only at the nominal period.
  always @(posedge ref_clk) begin
    if (ref_rst_n) begin
      n++;
      if (n >= 2*WIN+1 && (n % WIN) == 1) begin
        if (!pend_ok) begin
          fault_e = 1'b0; track_e = 1'b0; good_run = 0; tag = "R5";
        end else begin
          good_run = (good_run < 2) ? good_run + 1 : 2;
          track_e  = (good_run >= 2);
          fault_e  = pend_clean && sig_det && ref_lock;
          tag = "R4/R6";
        end
      end
      if ((n % WIN) == 0) begin
        pend_ok    = (rec_half == 4.0);
        pend_clean = armed && !dirty;
        armed      = sig_det && ref_lock;
        dirty      = 1'b0;
      end
    end
  end

  always @(negedge sig_det or negedge ref_lock) begin
    fault_e = 1'b0;
    dirty   = 1'b1;
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge ref_clk) begin
    if (!done) begin
      chk(ref_rst_n ? tag : "R1", fault_n, fault_e, "fault_n vs model");
      chk(ref_rst_n ? tag : "R1", track_data, track_e, "track_data vs model");
    end
  end

  task automatic wait_n(int k);
    while (n < k) @(negedge ref_clk);
  endtask

  initial begin
    repeat (4) @(negedge ref_clk);
    chk("R1", fault_n, 1'b0, "fault_n in reset");
    chk("R1", track_data, 1'b0, "track_data in reset");
    ref_rst_n = 1'b1;
    rec_rst_n = 1'b1;

    wait_n(300);  chk("R2", fault_n, 1'b0, "first window gives no verdict");
    wait_n(2*WIN+7);  chk("R4", fault_n, 1'b1, "release after clean window");
    chk("R6", track_data, 1'b0, "one good window is not enough");
    wait_n(3*WIN+10); chk("R6", track_data, 1'b1, "second good window");

    // R8/R3: sub-cycle glitch on sig_det
    wait_n(3*WIN+40);
    #1 sig_det = 1'b0;
    #0.5 chk("R3", fault_n, 1'b0, "immediate drop on sig_det fall");
    #1.5 sig_det = 1'b1;
    @(negedge ref_clk);
    chk("R8", fault_n, 1'b0, "glitch keeps fault until verdict");
    chk("R7", track_data, 1'b1, "track unaffected by status");
    wait_n(4*WIN+6);  chk("R8", fault_n, 1'b0, "dirty window not released");
    wait_n(5*WIN+6);  chk("R4", fault_n, 1'b1, "next clean window releases");

    // R5: fast recovered clock
    wait_n(5*WIN+9);  rec_half = 3.5;
    wait_n(6*WIN+6);  chk("R5", fault_n, 1'b0, "fast rate faults");
    chk("R5", track_data, 1'b0, "fast rate selects reference");
    wait_n(6*WIN+9);  rec_half = 4.0;
    wait_n(7*WIN+6);  chk("R6", track_data, 1'b0, "hysteresis after fast");
    chk("R4", fault_n, 1'b1, "release after fast");
    wait_n(8*WIN+6);  chk("R6", track_data, 1'b1, "track again");

    // R5: slow recovered clock
    wait_n(8*WIN+9);  rec_half = 5.0;
    wait_n(9*WIN+6);  chk("R5", fault_n, 1'b0, "slow rate faults");
    chk("R5", track_data, 1'b0, "slow rate selects reference");
    wait_n(9*WIN+9);  rec_half = 4.0;
    wait_n(10*WIN+6); chk("R4", fault_n, 1'b1, "release after slow");

    // R9: lock drop spanning a window boundary
    wait_n(10*WIN+100);
    #2 ref_lock = 1'b0;
    #0.5 chk("R3", fault_n, 1'b0, "immediate drop on ref_lock fall");
    wait_n(11*WIN+6); chk("R9", fault_n, 1'b0, "window with drop");
    wait_n(11*WIN+80);
    #2 ref_lock = 1'b1;
    wait_n(12*WIN+6); chk("R9", fault_n, 1'b0, "window opened while low");
    wait_n(13*WIN+6); chk("R9", fault_n, 1'b1, "release after boundary drop");
    chk("R7", track_data, 1'b1, "track kept through lock drop");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule